// File: doc/BRIEF.md
# Hybrid Branch Direction Predictor

This block guesses whether a conditional branch will be taken by combining two component predictors. One component looks at the outcomes of the most recent branches across the whole program and uses them to select a 2-bit counter. The other first looks up the outcome history of the branches that share the requesting address slot, then uses that history to select a 3-bit counter. A table of 2-bit selector counters, indexed by the global outcome history, decides for each lookup which of the two guesses is passed on.

A fetch stage offers an address on the lookup channel. The channel uses valid/ready handshakes. A lookup is accepted on a clock edge where `req_valid` and `req_ready` are both high. The guess appears on the response channel on the next cycle and is held there until the consumer raises `resp_ready`. While a response waits, `req_ready` is low, so back-pressure on the response side stalls new lookups. A resolved branch is reported on the training port. That port has no back-pressure: every cycle in which `upd_valid` is high is taken as one outcome. Training updates both component counters, the selector and both histories.

Top module: `tournament_predictor`

## Requirements
- R1: After reset `req_ready` is 1 and `resp_valid` is 0. All histories are zero. Every selector counter is 01 (weakly local). Global counters are 01 and local counters are 011 (weakly not taken). So the first lookup of any address returns not taken.
- R2: A lookup is accepted when `req_valid` and `req_ready` are both 1. `resp_valid` is 1 in the following cycle and carries that lookup's guess. `req_ready` equals `!resp_valid || resp_ready`. Responses come out in the order the lookups were accepted.
- R3: While `resp_valid` is 1 and `resp_ready` is 0, `resp_valid` stays 1, `resp_taken` holds its value, and no new lookup is accepted.
- R4: The guess comes from the global counter when the selector counter at the global-history index has its MSB set. Otherwise it comes from the local counter. Each component guesses taken when its counter MSB is 1.
- R5: There are 4096 global 2-bit counters, indexed by a 12-bit global history. Bit 0 of that history is the most recent training outcome, bit i is the outcome i+1 updates ago, and 1 means taken.
- R6: The local history table has 1024 entries of 10 bits each, indexed by address bits [11:2]. Bit 0 of an entry is the newest outcome. The entry indexes 1024 local 3-bit counters.
- R7: Each training event steps both selected component counters by one, with saturation: up on taken, down on not taken. The counters are selected with the histories as they were before the event. Then the local entry and the global history each shift in the outcome at bit 0. Without a training event, no history changes.
- R8: The selector counter moves up by one (toward global) when only the global component was right. It moves down by one when only the local component was right. It is left unchanged when both were right or both were wrong. It saturates at 0 and 3. Correctness is judged against the counters as they were before the event.
- R9: A lookup accepted in the same cycle as a training event sees the table and history contents from before that event.
- R10: Address bits [1:0] and bits above 11 have no effect. Two addresses that are equal in bits [11:2] share one local history entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Reset, active low |
| req_valid | input | 1 | Lookup offered |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_pc | input | 32 | Branch address of the lookup |
| resp_valid | output | 1 | Guess available |
| resp_ready | input | 1 | Consumer takes the guess this cycle |
| resp_taken | output | 1 | Guess: 1 taken, 0 not taken |
| upd_valid | input | 1 | Resolved branch reported this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome: 1 taken |

## Verification
A lookup and a training event can fall in the same cycle. They may even name the same address, so one slot of every table is both read and written in that cycle. The bench provokes this by driving both ports together on every cycle of several runs. These runs include a repeating loop pattern on one address and a mix of addresses with pseudo-random outcomes. A reference model computes each expected guess from its state as it stood before that cycle's training. Only then does the model apply the training. Every response is compared against that expected guess in the order it was produced.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef enum logic {
    PICK_LOCAL  = 1'b0,
    PICK_GLOBAL = 1'b1
  } pick_e;

  function automatic logic guess_right(input logic guess, input logic outcome);
    return guess == outcome;
  endfunction

endpackage

// File: rtl/tp_sat_table.sv
module tp_sat_table #(
  parameter int IDX_W = 12,
  parameter int CNT_W = 2,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_msb,
  input  logic [IDX_W-1:0] up_idx,
  output logic             up_msb,
  input  logic             wr_en,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MIN = '0;

  logic [CNT_W-1:0] ctr_q [DEPTH];
  logic [CNT_W-1:0] cur_cnt;
  logic [CNT_W-1:0] nxt_cnt;

  assign rd_msb  = ctr_q[rd_idx][CNT_W-1];
  assign cur_cnt = ctr_q[up_idx];
  assign up_msb  = cur_cnt[CNT_W-1];

  always_comb begin
    nxt_cnt = cur_cnt;
    if (wr_up) begin
      if (cur_cnt != CNT_MAX) nxt_cnt = cur_cnt + 1'b1;
    end else begin
      if (cur_cnt != CNT_MIN) nxt_cnt = cur_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= RST_VAL;
    end else if (wr_en) begin
      ctr_q[up_idx] <= nxt_cnt;
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [HIST_W-1:0] rd_hist,
  input  logic [IDX_W-1:0]  up_idx,
  output logic [HIST_W-1:0] up_hist,
  input  logic              wr_en,
  input  logic              wr_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];

  assign rd_hist = hist_q[rd_idx];
  assign up_hist = hist_q[up_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else if (wr_en) begin
      hist_q[up_idx] <= {up_hist[HIST_W-2:0], wr_bit};
    end
  end
endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
  parameter int HIST_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], shift_bit};
  end
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor
  import tp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int PC_LSB  = 2,
  parameter int GHIST_W = 12,
  parameter int LIDX_W  = 10,
  parameter int LHIST_W = 10,
  parameter int GCNT_W  = 2,
  parameter int LCNT_W  = 3,
  parameter int CCNT_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PC_W-1:0] req_pc,
  output logic            resp_valid,
  input  logic            resp_ready,
  output logic            resp_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  localparam int IDX_HI = PC_LSB + LIDX_W;
  localparam logic [GCNT_W-1:0] G_RST = {1'b0, {(GCNT_W-1){1'b1}}};
  localparam logic [LCNT_W-1:0] L_RST = {1'b0, {(LCNT_W-1){1'b1}}};
  localparam logic [CCNT_W-1:0] C_RST = {1'b0, {(CCNT_W-1){1'b1}}};

  logic [GHIST_W-1:0] ghist_q;
  logic [LIDX_W-1:0]  req_lidx, upd_lidx;
  logic [LHIST_W-1:0] req_lhist, upd_lhist;
  logic               g_rd_msb, l_rd_msb, c_rd_msb;
  logic               g_up_msb, l_up_msb, c_up_msb;
  logic               g_ok, l_ok;
  logic               chooser_wr;
  logic               req_fire;
  logic               guess;
  pick_e              pick;
  logic               unused_bits;

  assign req_lidx = req_pc[IDX_HI-1:PC_LSB];
  assign upd_lidx = upd_pc[IDX_HI-1:PC_LSB];
  assign unused_bits = ^{req_pc[PC_W-1:IDX_HI], req_pc[PC_LSB-1:0],
                         upd_pc[PC_W-1:IDX_HI], upd_pc[PC_LSB-1:0], c_up_msb};

  tp_ghist #(.HIST_W(GHIST_W)) u_ghist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (upd_valid),
    .shift_bit (upd_taken),
    .hist      (ghist_q)
  );

  tp_hist_table #(.IDX_W(LIDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (req_lidx),
    .rd_hist (req_lhist),
    .up_idx  (upd_lidx),
    .up_hist (upd_lhist),
    .wr_en   (upd_valid),
    .wr_bit  (upd_taken)
  );

  tp_sat_table #(.IDX_W(GHIST_W), .CNT_W(GCNT_W), .RST_VAL(G_RST)) u_gctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (ghist_q),
    .rd_msb (g_rd_msb),
    .up_idx (ghist_q),
    .up_msb (g_up_msb),
    .wr_en  (upd_valid),
    .wr_up  (upd_taken)
  );

  tp_sat_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W), .RST_VAL(L_RST)) u_lctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (req_lhist),
    .rd_msb (l_rd_msb),
    .up_idx (upd_lhist),
    .up_msb (l_up_msb),
    .wr_en  (upd_valid),
    .wr_up  (upd_taken)
  );

  // Selector trains only when exactly one component was right.
  assign g_ok       = guess_right(g_up_msb, upd_taken);
  assign l_ok       = guess_right(l_up_msb, upd_taken);
  assign chooser_wr = upd_valid && (g_ok != l_ok);

  tp_sat_table #(.IDX_W(GHIST_W), .CNT_W(CCNT_W), .RST_VAL(C_RST)) u_chooser (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (ghist_q),
    .rd_msb (c_rd_msb),
    .up_idx (ghist_q),
    .up_msb (c_up_msb),
    .wr_en  (chooser_wr),
    .wr_up  (g_ok)
  );

  assign pick  = pick_e'(c_rd_msb);
  assign guess = (pick == PICK_GLOBAL) ? g_rd_msb : l_rd_msb;

  assign req_ready = !resp_valid || resp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_taken <= 1'b0;
    end else if (req_fire) begin
      resp_valid <= 1'b1;
      resp_taken <= guess;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tp_chk.sv
module tp_chk #(
  parameter int GHIST_W = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               resp_valid,
  input logic               resp_ready,
  input logic               resp_taken,
  input logic               upd_valid,
  input logic               upd_taken,
  input logic [GHIST_W-1:0] ghist
);
  // R2
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);

  // R3
  hold_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_taken)));

  // R5
  ghist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> (ghist == {$past(ghist[GHIST_W-2:0]), $past(upd_taken)}));

  // R7
  ghist_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(ghist));
endmodule

bind tournament_predictor tp_chk #(.GHIST_W(GHIST_W)) u_tp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_taken (resp_taken),
  .upd_valid  (upd_valid),
  .upd_taken  (upd_taken),
  .ghist      (ghist_q)
);

// File: tb/test_tournament_predictor.sv
module test_tournament_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int GN = 4096;
  localparam int LN = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_pc = '0;
  logic        resp_valid;
  logic        resp_ready = 1'b1;
  logic        resp_taken;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit    exp;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  // reference state
  int m_g [GN];
  int m_c [GN];
  int m_l [LN];
  int m_h [LN];
  int m_gh;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tournament_predictor i_tournament_predictor (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_pc     (req_pc),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_taken (resp_taken),
    .upd_valid  (upd_valid),
    .upd_pc     (upd_pc),
    .upd_taken  (upd_taken)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lidx(input logic [31:0] pc);
    return int'((pc >> 2) & 32'h3FF);
  endfunction

  function automatic bit m_predict(input logic [31:0] pc);
    int h;
    h = m_h[lidx(pc)];
    if (m_c[m_gh] >= 2) return m_g[m_gh] >= 2;
    return m_l[h] >= 4;
  endfunction

  task automatic m_train(input logic [31:0] pc, input bit t);
    int  li, h;
    bit  gok, lok;
    li  = lidx(pc);
    h   = m_h[li];
    gok = ((m_g[m_gh] >= 2) == t);
    lok = ((m_l[h] >= 4) == t);
    if (gok && !lok && m_c[m_gh] < 3) m_c[m_gh]++;
    if (lok && !gok && m_c[m_gh] > 0) m_c[m_gh]--;
    if (t) begin
      if (m_g[m_gh] < 3) m_g[m_gh]++;
      if (m_l[h] < 7) m_l[h]++;
    end else begin
      if (m_g[m_gh] > 0) m_g[m_gh]--;
      if (m_l[h] > 0) m_l[h]--;
    end
    m_h[li] = ((h << 1) | int'(t)) & 32'h3FF;
    m_gh    = ((m_gh << 1) | int'(t)) & 32'hFFF;
  endtask

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // driver: one cycle of stimulus, expected items pushed before training
  task automatic step(input bit rv, input logic [31:0] rpc,
                      input bit uv, input logic [31:0] upc, input bit ut,
                      input string tag);
    exp_t e;
    req_valid = rv;
    req_pc    = rpc;
    upd_valid = uv;
    upd_pc    = upc;
    upd_taken = ut;
    @(negedge clk);
    if (rv && req_ready) begin
      e.exp = m_predict(rpc);
      e.tag = tag;
      sb_q.push_back(e);
    end
    if (uv) m_train(upc, ut);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    upd_valid = 1'b0;
  endtask

  // monitor: compare each response as it is consumed
  always @(negedge clk) begin
    if (rst_n && resp_valid && resp_ready) begin
      if (sb_q.size() == 0) begin
        check_eq("R2 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check_eq(e.tag, int'(resp_taken), int'(e.exp));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    check_eq("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit held;
    for (int i = 0; i < GN; i++) begin
      m_g[i] = 1;
      m_c[i] = 1;
    end
    for (int i = 0; i < LN; i++) begin
      m_l[i] = 3;
      m_h[i] = 0;
    end
    m_gh = 0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check_eq("R1 req_ready", int'(req_ready), 1);
    check_eq("R1 resp_valid", int'(resp_valid), 0);
    step(1, 32'h0000_0040, 0, '0, 0, "R1");
    check_eq("R1 first guess", int'(resp_taken), 0);
    // R2 response one cycle after accept, then drains
    check_eq("R2 resp_valid after accept", int'(resp_valid), 1);
    step(0, '0, 0, '0, 0, "R2");
    check_eq("R2 resp_valid drained", int'(resp_valid), 0);

    // R6 loop pattern on one address, lookup and training together
    for (int i = 0; i < 60; i++)
      step(1, 32'h0000_0400, 1, 32'h0000_0400, (i % 4) != 3, "R6");

    // R5 branch that copies the previous outcome of another
    for (int i = 0; i < 60; i++) begin
      bit a;
      lfsr = lfsr_next(lfsr);
      a = lfsr[0];
      step(0, '0, 1, 32'h0000_0800, a, "R5");
      step(1, 32'h0000_0900, 1, 32'h0000_0900, a, "R5");
    end

    // R8 mixed addresses, pseudo-random outcomes, selector training
    for (int i = 0; i < 80; i++) begin
      lfsr = lfsr_next(lfsr);
      step(1, 32'h0000_2000 + {27'd0, lfsr[4:2], 2'b00},
           1, 32'h0000_2000 + {27'd0, lfsr[4:2], 2'b00}, lfsr[7], "R8");
    end

    // R9 same address, alternating outcomes, same-cycle read and write
    for (int i = 0; i < 8; i++)
      step(1, 32'h0000_0500, 1, 32'h0000_0500, i[0], "R9");

    // R10 aliasing: high bits and bits [1:0] differ, slot 0x101 shared
    for (int i = 0; i < 20; i++)
      step(1, 32'hABC0_0407, 1, 32'h0000_0404, 1'b1, "R10");

    // R7 training only, then lookup (R4 selection)
    for (int i = 0; i < 20; i++)
      step(0, '0, 1, 32'h0000_3000, 1'b1, "R7");
    step(1, 32'h0000_3000, 0, '0, 0, "R7");
    step(1, 32'h0000_3004, 0, '0, 0, "R4");
    step(0, '0, 0, '0, 0, "R4");

    // R3 back-pressure
    step(1, 32'h0000_0400, 0, '0, 0, "R3");
    resp_ready = 1'b0;
    held = resp_taken;
    for (int i = 0; i < 3; i++) begin
      step(1, 32'h0000_0500, 0, '0, 0, "R3");
      check_eq("R3 resp_valid held", int'(resp_valid), 1);
      check_eq("R3 resp_taken held", int'(resp_taken), int'(held));
      check_eq("R3 req_ready low", int'(req_ready), 0);
    end
    resp_ready = 1'b1;
    step(0, '0, 0, '0, 0, "R3");
    check_eq("R3 released", int'(resp_valid), 0);

    repeat (3) step(0, '0, 0, '0, 0, "R2");
    check_eq("R2 all responses seen", sb_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule